// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block collects interrupt requests from a parameterised set of input pins (24 by default) and forwards them, one at a time, to the interrupt fabric of the chip. Each pin owns a 64-bit routing entry that holds the vector, the delivery mode, the destination, a mask bit and a few attribute bits. A rising edge on a pin latches a pending bit. The delivery scheduler picks the lowest-numbered pin that is both pending and unmasked, and presents that pin's routing fields on a valid/ready delivery port. The pending bit is cleared only when the receiver accepts the delivery.

Software reaches all internal registers through a 32-bit window pair. The first offset holds an index, and the second offset reads or writes the register that the index selects. The internal space holds an identifier register, a read-only version register, a read-as-zero arbitration slot and the routing table. Each table entry occupies two consecutive indices, low word first. Changing an entry takes effect on the next scheduler decision. Clearing a mask bit therefore releases an interrupt that was latched while the pin was masked.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After synchronous reset the index register is 0 and the identifier is 0. Every entry low word reads 0x00010000 (masked), every entry high word reads 0, no pin is pending and `dlv_valid` is low.
- R2: Bus offset 0x00 is the index register, readable and writable in bits 7:0, with bits 31:8 reading 0. Bus offset 0x10 is the data window. Every other offset reads 0 and ignores writes. Read data appears on `bus_rdata` at the clock edge that samples `bus_rd` and holds until the next read.
- R3: Index 0 is the identifier register. A write stores only bits 27:24 of the data, and a read returns those four bits in 27:24 with all other bits 0.
- R4: Index 1 reads (pin count − 1) in bits 23:16 and the version code (default 0x1) in bits 3:0, with all other bits 0. Index 2 always reads 0. Writes to index 1 and index 2 change nothing.
- R5: Entry n is at index 0x10+2n (bits 31:0) and at index 0x10+2n+1 (bits 63:32), and written values read back unchanged except bit 12, which always reads 0. Indices 3 to 0x0F and indices above the table read 0 and drop writes.
- R6: A rising edge on `pin_in[n]` sets pending bit n. A level held high, or a falling edge, causes no further delivery.
- R7: A pending pin whose mask bit (bit 16 of the low word) is 1 is not delivered and stays pending. Clearing the mask later delivers the pin.
- R8: When several pins are eligible, deliveries are issued in ascending pin order, one delivery for each latched edge.
- R9: Delivery fields come from the offered pin's entry: destination from bits 63:56, destination mode from bit 11, delivery mode from bits 10:8, vector from bits 7:0, polarity from bit 13 and trigger mode from bit 15.
- R10: While `dlv_valid` is high and `dlv_ready` is low, the valid signal and all delivery fields hold. The pending bit is cleared only on acceptance, and the cycle after an acceptance has `dlv_valid` low.
- R11: From idle, an edge sampled at clock edge k makes `dlv_valid` high after clock edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset (low 8 address bits) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Interrupt request pins |
| dlv_valid | output | 1 | Delivery offered |
| dlv_ready | input | 1 | Delivery accepted by receiver |
| dlv_dest | output | 8 | Destination field |
| dlv_dmode | output | 1 | Destination mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vec | output | 8 | Interrupt vector |
| dlv_pol | output | 1 | Pin polarity attribute |
| dlv_trig | output | 1 | Trigger mode attribute |

## Verification
Several properties are checked on every cycle. An offered delivery must hold stable until it is accepted, and the cycle after an acceptance must be idle. The pin on offer must still be pending. Every edge must land in the pending register, and a new offer must be for an unmasked pin with no eligible lower pin. The bench scenarios cover what those properties cannot see: the register map contents, the index decode, read-only and undefined slots, latency, and masked interrupts released by a later table write. They also check that the delivered fields match the bit positions of the entry and that each randomly chosen set of pins drains in ascending order.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;

  localparam logic [7:0] IX_IDENT   = 8'h00;
  localparam logic [7:0] IX_VERSION = 8'h01;
  localparam logic [7:0] IX_ARB     = 8'h02;
  localparam logic [7:0] IX_TABLE   = 8'h10;

  localparam logic [31:0] LO_RESET  = 32'h0001_0000;

  typedef struct packed {
    logic [7:0] dest;
    logic       dmode;
    logic [2:0] mode;
    logic [7:0] vec;
    logic       pol;
    logic       trig;
  } dlv_fields_t;

  function automatic dlv_fields_t entry_fields(input logic [63:0] e);
    dlv_fields_t f;
    f.dest  = e[63:56];
    f.dmode = e[11];
    f.mode  = e[10:8];
    f.vec   = e[7:0];
    f.pol   = e[13];
    f.trig  = e[15];
    return f;
  endfunction

endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         PW      = 5,
  parameter logic [3:0] VERSION = 4'h1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NPINS-1:0] mask_vec,
  input  logic [PW-1:0]    look_pin,
  output logic [63:0]      look_entry
);

  localparam logic [7:0] TOP_PIN = 8'(NPINS - 1);

  logic [7:0]  index_q;
  logic [3:0]  ident_q;
  logic [31:0] lo_mem [NPINS];
  logic [31:0] hi_mem [NPINS];

  logic [7:0]  tbl_off;
  logic [6:0]  ent_n;
  logic        ent_ok;
  logic [PW-1:0] ent_p;
  logic [31:0] win_rd;
  logic        win_wr;

  assign tbl_off = index_q - IX_TABLE;
  assign ent_n   = tbl_off[7:1];
  assign ent_ok  = (index_q >= IX_TABLE) && ({25'd0, ent_n} < NPINS);
  assign ent_p   = ent_n[PW-1:0];
  assign win_wr  = bus_wr && (bus_addr == OFS_WINDOW);

  always_comb begin
    win_rd = '0;
    if (index_q == IX_IDENT) begin
      win_rd[27:24] = ident_q;
    end else if (index_q == IX_VERSION) begin
      win_rd[23:16] = TOP_PIN;
      win_rd[3:0]   = VERSION;
    end else if (ent_ok) begin
      win_rd = index_q[0] ? hi_mem[ent_p] : lo_mem[ent_p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      ident_q <= '0;
      for (int n = 0; n < NPINS; n++) begin
        lo_mem[n] <= LO_RESET;
        hi_mem[n] <= '0;
      end
    end else begin
      if (bus_wr && (bus_addr == OFS_INDEX)) begin
        index_q <= bus_wdata[7:0];
      end
      if (win_wr) begin
        if (index_q == IX_IDENT) begin
          ident_q <= bus_wdata[27:24];
        end else if (ent_ok) begin
          if (index_q[0]) begin
            hi_mem[ent_p] <= bus_wdata;
          end else begin
            lo_mem[ent_p] <= {bus_wdata[31:13], 1'b0, bus_wdata[11:0]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == OFS_INDEX) begin
        bus_rdata <= {24'd0, index_q};
      end else if (bus_addr == OFS_WINDOW) begin
        bus_rdata <= win_rd;
      end else begin
        bus_rdata <= '0;
      end
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_mask
    assign mask_vec[g] = lo_mem[g][16];
  end

  assign look_entry = {hi_mem[look_pin], lo_mem[look_pin]};

endmodule

// File: rtl/irq_redir_pend.sv
module irq_redir_pend #(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] clr_vec,
  output logic [NPINS-1:0] rise_vec,
  output logic [NPINS-1:0] pend_q
);

  logic [NPINS-1:0] pin_q;

  assign rise_vec = pin_in & ~pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= '0;
      pend_q <= '0;
    end else begin
      pin_q  <= pin_in;
      pend_q <= (pend_q & ~clr_vec) | rise_vec;
    end
  end

endmodule

// File: rtl/irq_redir_sched.sv
module irq_redir_sched
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pend_q,
  input  logic [NPINS-1:0] mask_vec,
  output logic [PW-1:0]    look_pin,
  input  logic [63:0]      look_entry,
  output logic [NPINS-1:0] clr_vec,
  output logic [PW-1:0]    cur_pin,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output dlv_fields_t      dlv_q
);

  logic [NPINS-1:0] elig;
  logic             pick_any;
  logic [PW-1:0]    pick_pin;

  assign elig = pend_q & ~mask_vec;

  always_comb begin
    pick_any = 1'b0;
    pick_pin = '0;
    for (int n = NPINS - 1; n >= 0; n--) begin
      if (elig[n]) begin
        pick_any = 1'b1;
        pick_pin = PW'(n);
      end
    end
  end

  assign look_pin = pick_pin;

  always_comb begin
    clr_vec = '0;
    if (dlv_valid && dlv_ready) begin
      clr_vec[cur_pin] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid <= 1'b0;
      cur_pin   <= '0;
      dlv_q     <= '0;
    end else if (dlv_valid) begin
      if (dlv_ready) begin
        dlv_valid <= 1'b0;
      end
    end else if (pick_any) begin
      dlv_valid <= 1'b1;
      cur_pin   <= pick_pin;
      dlv_q     <= entry_fields(look_entry);
    end
  end

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [3:0] VERSION = 4'h1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output logic [7:0]       dlv_dest,
  output logic             dlv_dmode,
  output logic [2:0]       dlv_mode,
  output logic [7:0]       dlv_vec,
  output logic             dlv_pol,
  output logic             dlv_trig
);

  localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [NPINS-1:0] mask_vec;
  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] rise_vec;
  logic [NPINS-1:0] clr_vec;
  logic [PW-1:0]    look_pin;
  logic [PW-1:0]    cur_pin;
  logic [63:0]      look_entry;
  dlv_fields_t      dlv_q;

  irq_redir_regs #(.NPINS(NPINS), .PW(PW), .VERSION(VERSION)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .mask_vec   (mask_vec),
    .look_pin   (look_pin),
    .look_entry (look_entry)
  );

  irq_redir_pend #(.NPINS(NPINS)) pend_i (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .clr_vec  (clr_vec),
    .rise_vec (rise_vec),
    .pend_q   (pend_q)
  );

  irq_redir_sched #(.NPINS(NPINS), .PW(PW)) sched_i (
    .clk        (clk),
    .rst        (rst),
    .pend_q     (pend_q),
    .mask_vec   (mask_vec),
    .look_pin   (look_pin),
    .look_entry (look_entry),
    .clr_vec    (clr_vec),
    .cur_pin    (cur_pin),
    .dlv_valid  (dlv_valid),
    .dlv_ready  (dlv_ready),
    .dlv_q      (dlv_q)
  );

  assign dlv_dest  = dlv_q.dest;
  assign dlv_dmode = dlv_q.dmode;
  assign dlv_mode  = dlv_q.mode;
  assign dlv_vec   = dlv_q.vec;
  assign dlv_pol   = dlv_q.pol;
  assign dlv_trig  = dlv_q.trig;

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int NPINS = 24,
  parameter int PW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] rise_vec,
  input logic [NPINS-1:0] pend_q,
  input logic [NPINS-1:0] mask_vec,
  input logic [PW-1:0]    cur_pin,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [7:0]       dlv_dest,
  input logic             dlv_dmode,
  input logic [2:0]       dlv_mode,
  input logic [7:0]       dlv_vec,
  input logic             dlv_pol,
  input logic             dlv_trig
);

  logic [NPINS-1:0] elig_d;
  logic [NPINS-1:0] mask_d;
  logic [NPINS-1:0] below_cur;

  always_ff @(posedge clk) begin
    elig_d <= pend_q & ~mask_vec;
    mask_d <= mask_vec;
  end

  assign below_cur = (NPINS'(1) << cur_pin) - NPINS'(1);

  // R1: the cycle after reset has nothing pending and nothing offered
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!dlv_valid && (pend_q == '0)));

  // R6: every rising edge lands in the pending register
  p_edge_latched_r6: assert property (@(posedge clk) disable iff (rst)
    (rise_vec != '0) |=> ((pend_q & $past(rise_vec)) == $past(rise_vec)));

  // R7: a new offer never names a masked pin
  p_offer_unmasked_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(dlv_valid) |-> (!mask_d[cur_pin] && elig_d[cur_pin]));

  // R8: no lower-numbered pin was eligible when an offer was made
  p_lowest_first_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dlv_valid) |-> ((elig_d & below_cur) == '0));

  // R10: an offer holds with stable fields until accepted
  p_hold_offer_r10: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_dest) &&
      $stable(dlv_dmode) && $stable(dlv_mode) && $stable(dlv_vec) &&
      $stable(dlv_pol) && $stable(dlv_trig) && $stable(cur_pin)));

  // R10: the cycle after an acceptance is idle
  p_gap_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_ready) |=> !dlv_valid);

  // R10: the offered pin remains pending until accepted
  p_pending_on_offer_r10: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> pend_q[cur_pin]);

endmodule

bind irq_redir_ctrl irq_redir_chk #(.NPINS(NPINS), .PW(PW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rise_vec  (rise_vec),
  .pend_q    (pend_q),
  .mask_vec  (mask_vec),
  .cur_pin   (cur_pin),
  .dlv_valid (dlv_valid),
  .dlv_ready (dlv_ready),
  .dlv_dest  (dlv_dest),
  .dlv_dmode (dlv_dmode),
  .dlv_mode  (dlv_mode),
  .dlv_vec   (dlv_vec),
  .dlv_pol   (dlv_pol),
  .dlv_trig  (dlv_trig)
);

// File: tb/irq_redir_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_redir_ctrl_tb_top;

  localparam int NPINS = 24;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NPINS-1:0] pin_in = '0;
  logic             dlv_valid;
  logic             dlv_ready = 1'b0;
  logic [7:0]       dlv_dest;
  logic             dlv_dmode;
  logic [2:0]       dlv_mode;
  logic [7:0]       dlv_vec;
  logic             dlv_pol;
  logic             dlv_trig;

  always #2.5 clk = ~clk;

  irq_redir_ctrl #(.NPINS(NPINS)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_dest(dlv_dest), .dlv_dmode(dlv_dmode), .dlv_mode(dlv_mode),
    .dlv_vec(dlv_vec), .dlv_pol(dlv_pol), .dlv_trig(dlv_trig)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  logic [31:0] m_lo [NPINS];
  logic [31:0] m_hi [NPINS];
  logic [3:0]  m_id;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic bit is_entry(input logic [7:0] idx);
    return (idx >= 8'h10) && (int'(idx - 8'h10) / 2 < NPINS);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] idx);
    logic [31:0] r = '0;
    if (idx == 8'h00) r[27:24] = m_id;
    else if (idx == 8'h01) begin
      r[23:16] = 8'(NPINS - 1);
      r[3:0]   = 4'h1;
    end else if (is_entry(idx)) begin
      r = idx[0] ? m_hi[int'(idx - 8'h10) / 2] : m_lo[int'(idx - 8'h10) / 2];
    end
    return r;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idx_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, {24'd0, idx});
    bus_write(8'h10, d);
    if (idx == 8'h00) m_id = d[27:24];
    else if (is_entry(idx)) begin
      if (idx[0]) m_hi[int'(idx - 8'h10) / 2] = d;
      else        m_lo[int'(idx - 8'h10) / 2] = d & ~32'h0000_1000;
    end
  endtask

  task automatic idx_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(8'h00, {24'd0, idx});
    bus_read(8'h10, d);
  endtask

  task automatic pulse(input logic [NPINS-1:0] p);
    @(negedge clk); pin_in = p;
    @(negedge clk); pin_in = '0;
  endtask

  task automatic wait_dlv(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (dlv_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic accept();
    dlv_ready = 1'b1;
    @(negedge clk);
    dlv_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit got;
    void'($urandom(32'd20240611));
    for (int n = 0; n < NPINS; n++) begin m_lo[n] = 32'h0001_0000; m_hi[n] = '0; end
    m_id = '0;

    idle(5);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    chk("R1 no delivery after reset", {63'd0, dlv_valid}, 64'd0);
    bus_read(8'h00, rd);  chk("R1 index reg reset", {32'd0, rd}, 64'd0);
    bus_read(8'h10, rd);  chk("R1 ident reset", {32'd0, rd}, 64'd0);
    idx_read(8'h10, rd);  chk("R1 entry0 low reset", {32'd0, rd}, 64'h0001_0000);
    idx_read(8'h3F, rd);  chk("R1 entry23 high reset", {32'd0, rd}, 64'd0);
    idx_read(8'h3E, rd);  chk("R1 entry23 low reset", {32'd0, rd}, 64'h0001_0000);

    // R2 index register and decode
    bus_write(8'h00, 32'hFFFF_FF13);
    bus_read(8'h00, rd);  chk("R2 index readback", {32'd0, rd}, 64'h13);
    bus_write(8'h04, 32'h0000_0055);
    bus_read(8'h00, rd);  chk("R2 other offset write ignored", {32'd0, rd}, 64'h13);
    bus_read(8'h04, rd);  chk("R2 other offset reads zero", {32'd0, rd}, 64'd0);

    // R3 identifier
    idx_write(8'h00, 32'hFFFF_FFFF);
    idx_read(8'h00, rd);  chk("R3 ident field only", {32'd0, rd}, 64'h0F00_0000);

    // R4 version and arbitration slot
    idx_read(8'h01, rd);  chk("R4 version read", {32'd0, rd}, 64'h0017_0001);
    idx_write(8'h01, 32'hFFFF_FFFF);
    idx_read(8'h01, rd);  chk("R4 version write ignored", {32'd0, rd}, 64'h0017_0001);
    idx_write(8'h02, 32'hFFFF_FFFF);
    idx_read(8'h02, rd);  chk("R4 arbitration reads zero", {32'd0, rd}, 64'd0);

    // R5 entry map, bit 12, undefined indices
    idx_write(8'h1A, 32'hFFFF_FFFF);
    idx_read(8'h1A, rd);  chk("R5 entry5 low bit12 zero", {32'd0, rd}, 64'hFFFF_EFFF);
    idx_write(8'h1B, 32'h1234_5678);
    idx_read(8'h1B, rd);  chk("R5 entry5 high", {32'd0, rd}, 64'h1234_5678);
    idx_read(8'h1C, rd);  chk("R5 entry6 untouched", {32'd0, rd}, 64'h0001_0000);
    bus_write(8'h00, 32'h40); bus_write(8'h10, 32'hDEAD_BEEF);
    bus_read(8'h10, rd);  chk("R5 index above table reads zero", {32'd0, rd}, 64'd0);
    bus_write(8'h00, 32'h05); bus_write(8'h10, 32'hDEAD_BEEF);
    bus_read(8'h10, rd);  chk("R5 reserved index reads zero", {32'd0, rd}, 64'd0);

    // R7 masked pin stays pending, unmask releases it
    pulse(24'h000004);
    idle(6);
    chk("R7 masked pin not delivered", {63'd0, dlv_valid}, 64'd0);
    idx_write(8'h14, 32'h0000_0042);
    wait_dlv(got);
    chk("R7 unmask releases pending", {63'd0, got}, 64'd1);
    chk("R7 released vector", {56'd0, dlv_vec}, 64'h42);
    // R10 hold while not ready
    idle(5);
    chk("R10 valid held without ready", {63'd0, dlv_valid}, 64'd1);
    chk("R10 vector held without ready", {56'd0, dlv_vec}, 64'h42);
    accept();
    chk("R10 idle after accept", {63'd0, dlv_valid}, 64'd0);
    idle(6);
    chk("R10 single delivery per edge", {63'd0, dlv_valid}, 64'd0);

    // R9 field positions
    idx_write(8'h1F, 32'hA500_0000);
    idx_write(8'h1E, 32'h0000_AD3C);
    pulse(24'h000080);
    wait_dlv(got);
    chk("R9 delivery present", {63'd0, got}, 64'd1);
    chk("R9 destination", {56'd0, dlv_dest}, 64'hA5);
    chk("R9 destination mode", {63'd0, dlv_dmode}, 64'd1);
    chk("R9 delivery mode", {61'd0, dlv_mode}, 64'd5);
    chk("R9 vector", {56'd0, dlv_vec}, 64'h3C);
    chk("R9 polarity", {63'd0, dlv_pol}, 64'd1);
    chk("R9 trigger", {63'd0, dlv_trig}, 64'd1);
    accept();

    // R11 latency and R6 level behaviour
    idx_write(8'h16, 32'h0000_0033);
    idle(2);
    pin_in[3] = 1'b1;
    @(negedge clk);
    chk("R11 not valid after first edge", {63'd0, dlv_valid}, 64'd0);
    @(negedge clk);
    chk("R11 valid after second edge", {63'd0, dlv_valid}, 64'd1);
    accept();
    idle(10);
    chk("R6 held level no redelivery", {63'd0, dlv_valid}, 64'd0);
    pin_in[3] = 1'b0;
    idle(6);
    chk("R6 falling edge no delivery", {63'd0, dlv_valid}, 64'd0);
    pin_in[3] = 1'b1;
    wait_dlv(got);
    chk("R6 new rising edge delivers", {63'd0, got}, 64'd1);
    chk("R6 new edge vector", {56'd0, dlv_vec}, 64'h33);
    pin_in[3] = 1'b0;
    accept();

    // R8 random pin sets drain in ascending order
    for (int n = 0; n < NPINS; n++) begin
      idx_write(8'(16 + 2 * n), 32'(8'h20 + n));
    end
    for (int r = 0; r < 25; r++) begin
      logic [NPINS-1:0] set;
      set = NPINS'($urandom);
      if (r == 0) set = '1;
      if (r == 1) set = NPINS'(1) << (NPINS - 1);
      if (set == '0) set = NPINS'(1);
      pulse(set);
      for (int n = 0; n < NPINS; n++) begin
        if (set[n]) begin
          wait_dlv(got);
          chk($sformatf("R8 round %0d pin %0d delivered", r, n), {63'd0, got}, 64'd1);
          chk($sformatf("R8 round %0d ascending vector", r), {56'd0, dlv_vec}, 64'(8'h20 + n));
          accept();
        end
      end
      idle(4);
      chk($sformatf("R8 round %0d drained", r), {63'd0, dlv_valid}, 64'd0);
    end

    // R5 random register traffic against the model
    for (int i = 0; i < 300; i++) begin
      logic [7:0]  idx;
      logic [31:0] d;
      idx = 8'($urandom_range(0, 8'h47));
      d   = $urandom;
      if (!is_entry(idx) || idx[0] || d[16]) begin
        if ($urandom_range(0, 1) == 0) idx_write(idx, d);
      end
      idx_read(idx, rd);
      chk($sformatf("R5 random read index %0h", idx), {32'd0, rd}, {32'd0, exp_read(idx)});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule